// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block runs on the slow real-time clock, one tick per clock cycle, and manages a low-power state. Software asks for power-down by writing a 1 to the hibernate register. The block then removes the power-enable output and waits for an external wakeup pin. A wakeup is accepted only if the pin stays high for a programmed minimum number of ticks. When a wakeup is accepted, the block turns power back on and holds an active-low reset output for a programmed number of ticks. It then returns to normal running.

Two tick fields set the timing: the minimum wakeup duration and the reset hold length. Both are programmed through a small register interface. Each field sits at a fixed bit range of a 32-bit word, so a stored field is always a multiple of 32 ticks. The fields can be changed only while the block is running, so a sequence in progress never sees its limits change. The reset hold value must also be programmed before power-down.

Top module: `hib_seq`

## Requirements
- R1: After reset, pwr_en_o is 1 and rst_no is 1. Reads at offsets 0x20, 0x24 and 0x28 return 0.
- R2: In the running state, a write to offset 0x20 with data bit 0 set drops pwr_en_o in the cycle after the write edge. A write with bit 0 clear has no effect.
- R3: Offset 0x24 holds the wakeup filter count in data bits [15:5]. Writing all ones reads back 0x0000FFE0. The count in ticks is the stored word value.
- R4: Offset 0x28 holds the reset hold count in data bits [11:5]. Writing all ones reads back 0x00000FE0. The count in ticks is the stored word value.
- R5: The wakeup is accepted only after wake_i has been high for filter count + 1 consecutive ticks following hibernation. Until then pwr_en_o stays 0.
- R6: If wake_i falls before the wakeup is accepted, the block returns to hibernation. The full filter duration is then required again.
- R7: After the wakeup is accepted, pwr_en_o is 1 and rst_no is 0 for reset count + 1 ticks. The block then returns to running with rst_no at 1.
- R8: A count of 0 passes its step after a single tick, for both the filter and the reset hold.
- R9: Writes to offsets 0x24 and 0x28 are ignored while the block is not running.
- R10: A read of offset 0x20 returns bit 0 = 1 while the block is not running and 0 while it is running. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock; one cycle is one tick |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| wake_i | input | 1 | External wakeup pin, active high |
| pwr_en_o | output | 1 | Power enable, high while powered |
| rst_no | output | 1 | Active-low reset output to the powered domain |

## Verification
A wrong state shows at the ports within one tick. pwr_en_o, rst_no and bit 0 at offset 0x20 are all decoded from the state register, so a missed or early transition changes one of them on the next edge. Errors in the counter show up later, as an exit that comes too early or too late. The bench therefore samples exactly one tick before and one tick at each expected boundary. It also uses an interrupted wakeup to show that the filter count starts again from zero.

// File: rtl/hib_pkg.sv
package hib_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HIB  = 2'd1,
    ST_FILT = 2'd2,
    ST_HOLD = 2'd3
  } hib_state_e;
endpackage

// File: rtl/hib_regs.sv
module hib_regs #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] OFS_HIB  = 6'h20,
  parameter logic [ADDR_W-1:0] OFS_FILT = 6'h24,
  parameter logic [ADDR_W-1:0] OFS_RST  = 6'h28,
  parameter int FILT_MSB = 15,
  parameter int FILT_LSB = 5,
  parameter int RST_MSB  = 11,
  parameter int RST_LSB  = 5,
  localparam int CNT_W   = ((FILT_MSB > RST_MSB) ? FILT_MSB : RST_MSB) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              run_i,
  output logic              hib_req_o,
  output logic [CNT_W-1:0]  filt_ticks_o,
  output logic [CNT_W-1:0]  hold_ticks_o
);
  logic [FILT_MSB:FILT_LSB] filt_q;
  logic [RST_MSB:RST_LSB]   hold_q;

  // fields are frozen once a sequence is under way
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= '0;
      hold_q <= '0;
    end else if (we_i && run_i) begin
      if (addr_i == OFS_FILT) filt_q <= wdata_i[FILT_MSB:FILT_LSB];
      if (addr_i == OFS_RST)  hold_q <= wdata_i[RST_MSB:RST_LSB];
    end
  end

  assign hib_req_o    = we_i && (addr_i == OFS_HIB) && wdata_i[0];
  assign filt_ticks_o = CNT_W'({filt_q, {FILT_LSB{1'b0}}});
  assign hold_ticks_o = CNT_W'({hold_q, {RST_LSB{1'b0}}});

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_HIB)  rdata_o[0] = ~run_i;
    if (addr_i == OFS_FILT) rdata_o[FILT_MSB:FILT_LSB] = filt_q;
    if (addr_i == OFS_RST)  rdata_o[RST_MSB:RST_LSB] = hold_q;
  end

  assert_fields_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(filt_q) && $stable(hold_q)));
endmodule

// File: rtl/hib_fsm.sv
module hib_fsm
  import hib_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hib_req_i,
  input  logic             wake_i,
  input  logic [CNT_W-1:0] filt_ticks_i,
  input  logic [CNT_W-1:0] hold_ticks_i,
  output logic             run_o,
  output logic             pwr_en_o,
  output logic             rst_no
);
  hib_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_RUN: if (hib_req_i) begin
        state_d = ST_HIB;
        cnt_d   = '0;
      end
      ST_HIB: if (wake_i) begin
        state_d = ST_FILT;
        cnt_d   = '0;
      end
      ST_FILT: begin
        if (!wake_i) begin
          state_d = ST_HIB;
          cnt_d   = '0;
        end else if (cnt_q == filt_ticks_i) begin
          state_d = ST_HOLD;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (cnt_q == hold_ticks_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign run_o    = (state_q == ST_RUN);
  assign pwr_en_o = (state_q != ST_HIB) && (state_q != ST_FILT);
  assign rst_no   = (state_q != ST_HOLD);

  assert_enter_hib_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && hib_req_i) |=> !pwr_en_o);
  assert_filter_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILT) |-> (cnt_q <= filt_ticks_i));
  assert_drop_restarts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILT && !wake_i) |=> (state_q == ST_HIB && cnt_q == '0));
  assert_hold_powered_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_no |-> pwr_en_o);
  assert_hold_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> (cnt_q <= hold_ticks_i));
endmodule

// File: rtl/hib_seq.sv
module hib_seq #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] OFS_HIB  = 6'h20,
  parameter logic [ADDR_W-1:0] OFS_FILT = 6'h24,
  parameter logic [ADDR_W-1:0] OFS_RST  = 6'h28,
  parameter int FILT_MSB = 15,
  parameter int FILT_LSB = 5,
  parameter int RST_MSB  = 11,
  parameter int RST_LSB  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              wake_i,
  output logic              pwr_en_o,
  output logic              rst_no
);
  localparam int CNT_W = ((FILT_MSB > RST_MSB) ? FILT_MSB : RST_MSB) + 1;

  logic             run, hib_req;
  logic [CNT_W-1:0] filt_ticks, hold_ticks;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  hib_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .OFS_HIB(OFS_HIB), .OFS_FILT(OFS_FILT), .OFS_RST(OFS_RST),
    .FILT_MSB(FILT_MSB), .FILT_LSB(FILT_LSB),
    .RST_MSB(RST_MSB), .RST_LSB(RST_LSB)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .run_i(run), .hib_req_o(hib_req),
    .filt_ticks_o(filt_ticks), .hold_ticks_o(hold_ticks)
  );

  hib_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hib_req_i(hib_req), .wake_i(wake_i),
    .filt_ticks_i(filt_ticks), .hold_ticks_i(hold_ticks),
    .run_o(run), .pwr_en_o(pwr_en_o), .rst_no(rst_no)
  );
endmodule

// File: tb/sim_hib_seq.sv
module sim_hib_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wake = 1'b0;
  logic        pwr_en, rst_o_n;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  hib_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .wake_i(wake),
    .pwr_en_o(pwr_en), .rst_no(rst_o_n)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    we = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 pwr_en", 32'(pwr_en), 32'd1);
    chk("R1 rst_no", 32'(rst_o_n), 32'd1);
    rd(6'h20, v); chk("R1 hib reg", v, 32'h0);
    rd(6'h24, v); chk("R1 filt reg", v, 32'h0);
    rd(6'h28, v); chk("R1 hold reg", v, 32'h0);
  endtask

  task automatic t_masks();
    logic [31:0] v;
    wr(6'h24, 32'hFFFF_FFFF);
    rd(6'h24, v); chk("R3 filt mask", v, 32'h0000_FFE0);
    wr(6'h28, 32'hFFFF_FFFF);
    rd(6'h28, v); chk("R4 hold mask", v, 32'h0000_0FE0);
    rd(6'h30, v); chk("R10 unmapped", v, 32'h0);
  endtask

  task automatic t_zero_write();
    logic [31:0] v;
    wr(6'h20, 32'hFFFF_FFFE);
    chk("R2 bit0 clear ignored", 32'(pwr_en), 32'd1);
    rd(6'h20, v); chk("R10 running", v, 32'h0);
  endtask

  task automatic t_full(logic [31:0] fv, logic [31:0] rv);
    logic [31:0] v;
    int nf, nr;
    nf = int'(fv & 32'hFFE0);
    nr = int'(rv & 32'h0FE0);
    wr(6'h24, fv);
    wr(6'h28, rv);
    wr(6'h20, 32'h1);
    chk("R2 power dropped", 32'(pwr_en), 32'd0);
    rd(6'h20, v); chk("R10 hibernating", v, 32'h1);
    wake = 1'b1;
    tick(nf + 1);
    chk("R5 still filtering", 32'(pwr_en), 32'd0);
    chk("R5 no reset yet", 32'(rst_o_n), 32'd1);
    tick(1);
    chk("R7 power back", 32'(pwr_en), 32'd1);
    chk("R7 reset low", 32'(rst_o_n), 32'd0);
    if (nr > 0) begin
      tick(nr);
      chk("R7 reset still low", 32'(rst_o_n), 32'd0);
    end
    tick(1);
    chk("R7 reset released", 32'(rst_o_n), 32'd1);
    rd(6'h20, v); chk("R10 running again", v, 32'h0);
    wake = 1'b0;
  endtask

  task automatic t_glitch_frozen();
    logic [31:0] v;
    wr(6'h24, 32'h40);
    wr(6'h28, 32'h20);
    wr(6'h20, 32'h1);
    wr(6'h24, 32'h1000);
    wr(6'h28, 32'h0);
    rd(6'h24, v); chk("R9 filt frozen", v, 32'h40);
    rd(6'h28, v); chk("R9 hold frozen", v, 32'h20);
    wake = 1'b1;
    tick(10);
    wake = 1'b0;
    tick(1);
    chk("R6 back to hibernate", 32'(pwr_en), 32'd0);
    rd(6'h20, v); chk("R6 not running", v, 32'h1);
    tick(3);
    wake = 1'b1;
    tick(64 + 1);
    chk("R6 full filter needed", 32'(pwr_en), 32'd0);
    tick(1);
    chk("R6 accepted after restart", 32'(rst_o_n), 32'd0);
    tick(32);
    chk("R7 hold 32", 32'(rst_o_n), 32'd0);
    tick(1);
    chk("R7 hold done", 32'(rst_o_n), 32'd1);
    wake = 1'b0;
  endtask

  task automatic t_zero_counts();
    wr(6'h24, 32'h1F);
    wr(6'h28, 32'h1F);
    wr(6'h20, 32'h1);
    wake = 1'b1;
    tick(1);
    chk("R8 one filter tick", 32'(pwr_en), 32'd0);
    tick(1);
    chk("R8 hold entered", 32'(rst_o_n), 32'd0);
    tick(1);
    chk("R8 one hold tick", 32'(rst_o_n), 32'd1);
    wake = 1'b0;
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_masks();
    t_zero_write();
    t_full(32'hFFFF_0020, 32'h0000_0040);
    t_glitch_frozen();
    t_zero_counts();
    tick(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule